// File: doc/BRIEF.md
# Disk Write Bit Serializer

This block turns bytes from a write latch into the serial bit stream that goes to a floppy write head. Bit timing is a fixed grid counted in CPU-cycle ticks: each bit is held on the output for a fixed number of ticks (four by default). A normal byte therefore lasts 32 ticks. A self-sync byte lasts 40 ticks: it is sent as eight ones followed by two zeros. The caller marks a byte as self-sync with a flag, and the byte value is then ignored.

A small state machine drives the block. Its states are `ST_IDLE` (nothing to send), `ST_DATA` (the eight data bits are being shifted) and `ST_TAIL` (the two trailing zeros of a self-sync frame). The transitions are:
- `ST_IDLE`→`ST_DATA` when a byte is accepted.
- `ST_DATA`→`ST_TAIL` when the eighth bit of a self-sync frame ends.
- `ST_DATA`→`ST_DATA` or `ST_TAIL`→`ST_DATA` when the next byte is accepted as the current frame ends.
- `ST_DATA`→`ST_IDLE` or `ST_TAIL`→`ST_IDLE` when a frame ends and no byte is offered.

`ready` goes high on the final clock of the last bit slot. A byte offered on that clock follows the current one with no gap in the bit grid.

Top module: `disk_wr_serializer`

## Requirements
- R1: After reset, `ready` is 1, `bit_valid` is 0 and `bit_out` is 0.
- R2: `bit_valid` is a one-clock strobe that marks the end of a bit slot. It fires on the clock that carries the 4th `tick` after the byte was accepted, or after the previous strobe. Clocks with `tick` low do not advance the slot.
- R3: A normal byte (`wr_sync`=0) is sent most-significant bit first as 8 slots, which is 32 ticks.
- R4: A byte accepted with `wr_sync`=1 is sent as the 10-slot pattern 1111111100 (40 ticks), whatever the value on `wr_byte`.
- R5: `ready` is 1 while idle, and on the clock where the last slot of a frame ends (the clock of that slot's strobe). It is 0 at all other times. A byte is accepted on a clock where `wr_valid` and `ready` are both 1.
- R6: A byte accepted on the final clock of a frame starts its first slot on the next clock, so the strobe spacing across the frame boundary stays exactly 4 ticks.
- R7: If no byte is accepted when a frame ends, the block goes idle: `bit_out` is 0 and `bit_valid` stays 0 until a new byte is accepted.
- R8: `wr_valid`, `wr_byte` and `wr_sync` are ignored on clocks where `ready` is 0. The bit stream is unchanged by them.
- R9: `bit_out` holds the same value for every clock of a bit slot and changes only after the slot's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | CPU-cycle enable; one bit slot spans 4 ticks |
| wr_byte | input | 8 | Byte to send |
| wr_valid | input | 1 | Byte offered this clock |
| wr_sync | input | 1 | 1: send a self-sync frame instead of `wr_byte` |
| bit_out | output | 1 | Serial bit for the write head |
| bit_valid | output | 1 | Strobe at the end of each bit slot |
| ready | output | 1 | A byte may be accepted this clock |

## Verification
A slot counter that is off by one shows up at the next strobe: it arrives one tick early or late, and the bench compares strobe timing on every clock. A shift register or bit index in the wrong state changes `bit_out` inside the current slot. It also moves the `ready` pulse for the last slot by a whole slot, so the error appears within 4 ticks. A state machine stuck in `ST_TAIL`, or one that drops to idle too early, alters the trailing zeros or the gap-free join. The mismatch shows before the next frame's first strobe.

// File: rtl/wser_pkg.sv
package wser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } wser_state_e;
endpackage

// File: rtl/wser_slot_timer.sv
module wser_slot_timer #(
    parameter int TICKS_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic slot_end
);
    localparam int CW = $clog2(TICKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    assign slot_end = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= slot_end ? '0 : cnt + 1'b1;
        end
    end

    generate
        if (TICKS_PER_BIT > 1) begin : g_spacing
            // R2
            slot_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                slot_end |=> !slot_end);
        end
    endgenerate
endmodule

// File: rtl/wser_shifter.sv
module wser_shifter #(
    parameter int DATA_BITS  = 8,
    parameter int SYNC_EXTRA = 2,
    localparam int FRAME_BITS = DATA_BITS + SYNC_EXTRA,
    localparam int IW = $clog2(FRAME_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 load_sync,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 shift,
    output logic                 head_bit,
    output logic [IW-1:0]        idx,
    output logic                 frame_sync
);
    localparam logic [IW-1:0] FLAST = IW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sr;

    assign head_bit = sr[FRAME_BITS-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr         <= '0;
            idx        <= '0;
            frame_sync <= 1'b0;
        end else if (load) begin
            sr         <= load_sync ? {{DATA_BITS{1'b1}}, {SYNC_EXTRA{1'b0}}}
                                    : {load_data, {SYNC_EXTRA{1'b0}}};
            idx        <= '0;
            frame_sync <= load_sync;
        end else if (shift) begin
            sr  <= {sr[FRAME_BITS-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= FLAST);
endmodule

// File: rtl/disk_wr_serializer.sv
module disk_wr_serializer
    import wser_pkg::*;
#(
    parameter int TICKS_PER_BIT = 4,
    parameter int DATA_BITS     = 8,
    parameter int SYNC_EXTRA    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [DATA_BITS-1:0] wr_byte,
    input  logic                 wr_valid,
    input  logic                 wr_sync,
    output logic                 bit_out,
    output logic                 bit_valid,
    output logic                 ready
);
    localparam int FRAME_BITS = DATA_BITS + SYNC_EXTRA;
    localparam int IW = $clog2(FRAME_BITS + 1);
    localparam logic [IW-1:0] DLAST = IW'(DATA_BITS - 1);
    localparam logic [IW-1:0] FLAST = IW'(FRAME_BITS - 1);

    wser_state_e state, state_nx;
    logic        slot_end, last_slot, frame_done, accept, shift;
    logic        head_bit, frame_sync;
    logic [IW-1:0] idx;

    wser_slot_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state != ST_IDLE),
        .restart  (accept),
        .tick     (tick),
        .slot_end (slot_end)
    );

    wser_shifter #(.DATA_BITS(DATA_BITS), .SYNC_EXTRA(SYNC_EXTRA)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_sync  (wr_sync),
        .load_data  (wr_byte),
        .shift      (shift),
        .head_bit   (head_bit),
        .idx        (idx),
        .frame_sync (frame_sync)
    );

    assign last_slot  = ((state == ST_DATA) && !frame_sync && (idx == DLAST)) ||
                        ((state == ST_TAIL) && (idx == FLAST));
    assign frame_done = last_slot && slot_end;
    assign ready      = (state == ST_IDLE) || frame_done;
    assign accept     = wr_valid && ready;
    assign shift      = slot_end && !frame_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_DATA;
            ST_DATA: begin
                if (slot_end && (idx == DLAST)) begin
                    if (frame_sync)  state_nx = ST_TAIL;
                    else if (accept) state_nx = ST_DATA;
                    else             state_nx = ST_IDLE;
                end
            end
            ST_TAIL: begin
                if (frame_done) state_nx = accept ? ST_DATA : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        bit_out   = (state != ST_IDLE) ? head_bit : 1'b0;
        bit_valid = slot_end;
    end

    // R4
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (bit_out == 1'b0));
    // R4
    tail_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> frame_sync);
    // R7
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !accept) |=> (state == ST_IDLE));
    // R6
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && accept) |=> ((state == ST_DATA) && (idx == '0)));
endmodule

// File: tb/disk_wr_serializer_test.sv
module disk_wr_serializer_test;
    localparam int TPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_valid = 1'b0;
    logic       wr_sync = 1'b0;
    logic       bit_out, bit_valid, ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit   q[$];
    int   tcount = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    disk_wr_serializer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_byte(wr_byte),
        .wr_valid(wr_valid), .wr_sync(wr_sync), .bit_out(bit_out),
        .bit_valid(bit_valid), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d", req, phase, what, act, exp);
        end
    endtask

    function automatic bit exp_ready_f(input bit t);
        return (q.size() == 0) || (q.size() == 1 && t && tcount == TPB - 1);
    endfunction

    // one clock: drive, compare, advance model
    task automatic cyc(input int tprob, input bit have, input logic [7:0] b,
                       input bit s, input bit junk, output bit acc);
        bit er, ebv, ebo;
        @(negedge clk);
        tick = ($urandom % 100) < tprob;
        #1;
        er  = exp_ready_f(tick);
        ebv = (q.size() > 0) && tick && (tcount == TPB - 1);
        ebo = (q.size() > 0) ? q[0] : 1'b0;
        acc = have && er;
        if (acc) begin
            wr_valid = 1'b1; wr_byte = b; wr_sync = s;
        end else begin
            wr_valid = junk && !er && ($urandom % 2 == 1);
            wr_byte  = 8'($urandom);
            wr_sync  = 1'($urandom);
        end
        #1;
        check(ready == er, "R5", "ready", ready, er);
        check(bit_valid == ebv, "R2", "bit_valid", bit_valid, ebv);
        check(bit_out == ebo, (q.size() == 0) ? "R7" : "R9", "bit_out", bit_out, ebo);
        if (ebv) begin
            void'(q.pop_front());
            tcount = 0;
        end else if (tick && q.size() > 0) begin
            tcount++;
        end
        if (acc) begin
            tcount = 0;
            for (int i = 7; i >= 0; i--) q.push_back(s ? 1'b1 : b[i]);
            if (s) begin q.push_back(1'b0); q.push_back(1'b0); end
        end
    endtask

    task automatic send(input int tprob, input logic [7:0] b, input bit s, input bit junk);
        bit acc;
        acc = 1'b0;
        while (!acc) cyc(tprob, 1'b1, b, s, junk, acc);
    endtask

    task automatic idle(input int tprob, input int n, input bit junk);
        bit acc;
        for (int i = 0; i < n; i++) cyc(tprob, 1'b0, 8'h00, 1'b0, junk, acc);
    endtask

    initial begin
        void'($urandom(32'h5eed_d15c));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(ready == 1'b1, "R1", "ready", ready, 1);
        check(bit_valid == 1'b0, "R1", "bit_valid", bit_valid, 0);
        check(bit_out == 1'b0, "R1", "bit_out", bit_out, 0);

        // R3 single normal byte, MSB first, then R7 idle
        phase = "R3";
        send(100, 8'hA5, 1'b0, 1'b0);
        idle(100, 40, 1'b0);
        phase = "R7";
        idle(100, 10, 1'b0);

        // R4 self-sync frame, byte value ignored
        phase = "R4";
        send(100, 8'h00, 1'b1, 1'b0);
        idle(100, 50, 1'b0);

        // R6 back-to-back frames across both frame kinds
        phase = "R6";
        send(100, 8'h81, 1'b0, 1'b0);
        send(100, 8'h3C, 1'b1, 1'b0);
        send(100, 8'hFF, 1'b0, 1'b0);
        send(100, 8'h01, 1'b1, 1'b0);
        idle(100, 50, 1'b0);

        // R2 sparse ticks, R8 junk while not ready
        phase = "R8";
        for (int k = 0; k < 20; k++) send(30, 8'($urandom), 1'($urandom % 4 == 0), 1'b1);
        idle(30, 200, 1'b1);

        // random mix
        phase = "R2";
        for (int k = 0; k < 300; k++) begin
            send(20 + $urandom % 81, 8'($urandom), 1'($urandom % 5 == 0), 1'b1);
            if ($urandom % 4 == 0) idle(100, $urandom % 60, 1'b1);
        end
        idle(100, 60, 1'b0);
        check(q.size() == 0, "R7", "drained", q.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (%s): actual hung expected done", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule